// File: doc/BRIEF.md
# I2C Bus Quiet Detector and Bridge Connect Gate

This block sits at one end of an isolated I2C bridge and decides when the bridge's line drivers may be switched on. It watches the local SDA and SCL levels, already reduced to one logic bit each, together with a "far side is quiet" flag delivered by the isolation link. All three inputs pass through a synchronizer before they are used. From the synchronized lines it picks out START and STOP conditions, and it times how long both lines have been high using a restartable microsecond timer.

The local bus counts as quiet in two cases. The first is when both lines have stayed high for the configured idle time. The second is when a STOP has been seen and both lines have stayed high ever since. The local quiet state goes out to the far side. The drivers are enabled once the local side and the far side are both quiet. After that, the enable stays on through normal traffic until a disconnect request arrives. A disconnect request drops the enable and wipes all quiet history, so a new connection needs a fresh quiet period.

Top module: `i2c_quiet_gate`

## Requirements
- R1: With both synchronized lines high, `local_quiet` rises after exactly N = CLK_PER_US × IDLE_US consecutive clock edges at which both were high. With the bench configuration (N = 15), that is the 17th edge after both raw lines go high.
- R2: A STOP is SDA going from 0 to 1 while SCL is 1 in both the current and the previous synchronized sample. `stop_det` is 1 for that one cycle, and `local_quiet` is 1 from the next cycle onward while both lines stay high.
- R3: Any cycle in which either synchronized line is 0 clears the idle timer and the post-STOP state. `local_quiet` is 0 in the following cycle, and a high stretch shorter than N edges never raises it.
- R4: A START is SDA going from 1 to 0 while SCL is 1 in both the current and the previous sample. `start_det` is 1 for that cycle, and the post-STOP quiet state is gone one cycle later.
- R5: `drv_en` (1 = drivers on) rises only in the cycle after `local_quiet` and the synchronized `far_quiet` were both 1 while `drop_req` was 0.
- R6: Once `drv_en` is 1, it stays 1 through any bus activity and through loss of `far_quiet` until `drop_req` is sampled high.
- R7: `drop_req` sampled high drives `drv_en` and `local_quiet` to 0 at that edge. Re-enabling then requires a full new quiet period: N further edges with both lines high, or a new STOP.
- R8: The synchronous reset `rst` forces `drv_en`, `local_quiet`, `start_det` and `stop_det` to 0, and clears the synchronizers to the low level.
- R9: `sda_in`, `scl_in` and `far_quiet` pass through a SYNC_STAGES-deep synchronizer (2 by default) before any decision uses them. `drop_req` is used without a synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sda_in | input | 1 | Local data line level (1 = high) |
| scl_in | input | 1 | Local clock line level (1 = high) |
| far_quiet | input | 1 | Far side reports its bus quiet (asynchronous) |
| drop_req | input | 1 | Disconnect request from stuck-bus, link-loss or power monitors |
| local_quiet | output | 1 | Local bus is quiet (sent to far side) |
| drv_en | output | 1 | Enable for the bridge drivers, registered |
| start_det | output | 1 | One-cycle pulse on a START |
| stop_det | output | 1 | One-cycle pulse on a STOP |

## Verification
A wrong idle counter or prescaler shows as `local_quiet` rising early or late relative to the N-edge window. A stale post-STOP flag shows as `local_quiet` staying high through a START or a low level. Both errors reach the port within one cycle of the state going wrong, and reach `drv_en` one cycle after that. A connection state that fails to hold or fails to clear shows directly on `drv_en` at the edge after the traffic or the disconnect request. The bench therefore checks the exact edge of every transition, and it sweeps every high-stretch length around the idle threshold.

// File: rtl/qg_pkg.sv
package qg_pkg;

  typedef enum logic {
    LINK_OFF = 1'b0,
    LINK_ON  = 1'b1
  } link_state_e;

  // Bits needed to hold values 0..maxval
  function automatic int cnt_width(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Clock edges of continuous high needed for idle-quiet
  function automatic int idle_cycles(input int clk_per_us, input int idle_us);
    return clk_per_us * idle_us;
  endfunction

endpackage

// File: rtl/qg_sync.sv
module qg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qg_idle_timer.sv
module qg_idle_timer
  import qg_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int IDLE_US    = 115
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic us_tick,
  output logic idle_done
);
  localparam int UW = cnt_width(IDLE_US);
  localparam logic [UW-1:0] US_MAX = UW'(IDLE_US);

  logic [UW-1:0] us_cnt;

  if (CLK_PER_US == 1) begin : g_no_prescale
    assign us_tick = run;
  end else begin : g_prescale
    localparam int PW = cnt_width(CLK_PER_US - 1);
    localparam logic [PW-1:0] PC_LAST = PW'(CLK_PER_US - 1);
    logic [PW-1:0] pc;

    always_ff @(posedge clk) begin
      if (rst || !run)        pc <= '0;
      else if (pc == PC_LAST) pc <= '0;
      else                    pc <= pc + 1'b1;
    end

    assign us_tick = run && (pc == PC_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)                   us_cnt <= '0;
    else if (us_tick && us_cnt != US_MAX) us_cnt <= us_cnt + 1'b1;
  end

  assign idle_done = (us_cnt == US_MAX);
endmodule

// File: rtl/qg_bus_events.sv
module qg_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sda,
  input  logic scl,
  output logic start_evt,
  output logic stop_evt,
  output logic after_stop
);
  logic sda_d, scl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_d <= 1'b0;
      scl_d <= 1'b0;
    end else begin
      sda_d <= sda;
      scl_d <= scl;
    end
  end

  assign stop_evt  =  sda && !sda_d && scl && scl_d;
  assign start_evt = !sda &&  sda_d && scl && scl_d;

  always_ff @(posedge clk) begin
    if (rst || clear || !sda || !scl) after_stop <= 1'b0;
    else if (stop_evt)                after_stop <= 1'b1;
  end
endmodule

// File: rtl/i2c_quiet_gate.sv
module i2c_quiet_gate
  import qg_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int IDLE_US     = 115,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic far_quiet,
  input  logic drop_req,
  output logic local_quiet,
  output logic drv_en,
  output logic start_det,
  output logic stop_det
);
  localparam int IDLE_EDGES = idle_cycles(CLK_PER_US, IDLE_US);

  logic [2:0]  raw_vec, sync_vec;
  logic        sda_s, scl_s, far_s;
  logic        both_high, timer_run, us_tick, idle_done;
  logic        start_evt, stop_evt, after_stop;
  logic        connect_ok;
  link_state_e link_q;

  assign raw_vec = {far_quiet, scl_in, sda_in};

  qg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_vec), .q(sync_vec)
  );

  assign sda_s = sync_vec[0];
  assign scl_s = sync_vec[1];
  assign far_s = sync_vec[2];

  assign both_high = sda_s && scl_s;
  assign timer_run = both_high && !drop_req;

  qg_idle_timer #(.CLK_PER_US(CLK_PER_US), .IDLE_US(IDLE_US)) u_timer (
    .clk(clk), .rst(rst), .run(timer_run),
    .us_tick(us_tick), .idle_done(idle_done)
  );

  qg_bus_events u_events (
    .clk(clk), .rst(rst), .clear(drop_req),
    .sda(sda_s), .scl(scl_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .after_stop(after_stop)
  );

  assign local_quiet = (idle_done || after_stop) && (IDLE_EDGES > 0);
  assign connect_ok  = local_quiet && far_s && !drop_req;

  always_ff @(posedge clk) begin
    if (rst || drop_req)                      link_q <= LINK_OFF;
    else if (link_q == LINK_OFF && connect_ok) link_q <= LINK_ON;
  end

  assign drv_en    = (link_q == LINK_ON);
  assign start_det = start_evt;
  assign stop_det  = stop_evt;
endmodule

// File: rtl/qg_checker.sv
module qg_checker (
  input logic clk,
  input logic rst,
  input logic drv_en,
  input logic local_quiet,
  input logic drop_req,
  input logic sda_s,
  input logic scl_s,
  input logic stop_evt,
  input logic connect_ok
);
  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !drop_req) |=> local_quiet);

  assert_low_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (!sda_s || !scl_s) |=> !local_quiet);

  assert_rise_needs_both_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> $past(connect_ok));

  assert_enable_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (drv_en && !drop_req) |=> drv_en);

  assert_drop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    drop_req |=> (!drv_en && !local_quiet));

  assert_reset_off_R8: assert property (@(posedge clk)
    rst |=> (!drv_en && !local_quiet));
endmodule

bind i2c_quiet_gate qg_checker u_chk (
  .clk(clk), .rst(rst), .drv_en(drv_en), .local_quiet(local_quiet),
  .drop_req(drop_req), .sda_s(sda_s), .scl_s(scl_s),
  .stop_evt(stop_evt), .connect_ok(connect_ok)
);

// File: tb/i2c_quiet_gate_tb_top.sv
module i2c_quiet_gate_tb_top;
  localparam int CPU = 3;
  localparam int IUS = 5;
  localparam int N   = CPU * IUS;

  logic clk = 1'b0;
  logic rst, sda, scl, far, drop;
  logic local_quiet, drv_en, start_det, stop_det;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  i2c_quiet_gate #(.CLK_PER_US(CPU), .IDLE_US(IUS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .far_quiet(far),
    .drop_req(drop), .local_quiet(local_quiet), .drv_en(drv_en),
    .start_det(start_det), .stop_det(stop_det)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drop_pulse();
    drop = 1'b1;
    step(1);
    check("R7 drv_en off after drop", drv_en, 1'b0);
    check("R7 quiet off after drop", local_quiet, 1'b0);
    drop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sda = 1'b1; scl = 1'b1; far = 1'b0; drop = 1'b0;
    @(negedge clk);
    step(3);
    check("R8 reset drv_en", drv_en, 1'b0);
    check("R8 reset quiet", local_quiet, 1'b0);
    check("R8 reset stop_det", stop_det, 1'b0);
    check("R8 reset start_det", start_det, 1'b0);
    rst = 1'b0;

    // R1: idle quiet after N both-high edges, two sync stages ahead
    step(N + 1);
    check("R1 quiet not yet", local_quiet, 1'b0);
    check("R1 rising edge not a STOP", stop_det, 1'b0);
    step(1);
    check("R1 quiet at N edges", local_quiet, 1'b1);
    step(3);
    check("R5 no enable without far", drv_en, 1'b0);

    // R5/R9: far_quiet through the synchronizer
    far = 1'b1;
    step(2);
    check("R9 far not yet through sync", drv_en, 1'b0);
    step(1);
    check("R5 enable after both quiet", drv_en, 1'b1);

    // R6: traffic and far loss keep the enable
    far = 1'b0;
    for (int i = 0; i < 12; i++) begin
      scl = i[0];
      sda = i[1];
      step(1);
      check("R6 enable held in traffic", drv_en, 1'b1);
    end
    sda = 1'b1; scl = 1'b1; far = 1'b1;
    step(3);

    // R7: drop needs a new full idle period
    drop_pulse();
    step(N - 1);
    check("R7 quiet not before new idle", local_quiet, 1'b0);
    step(1);
    check("R7 quiet after new idle", local_quiet, 1'b1);
    check("R7 drv_en still off", drv_en, 1'b0);
    step(1);
    check("R7 re-enable", drv_en, 1'b1);

    // R3: sweep high stretches around the threshold
    far = 1'b0;
    drop_pulse();
    for (int len = 1; len <= N + 2; len++) begin
      logic peak;
      sda = 1'b0; scl = 1'b0;
      step(4);
      check("R3 low gives no quiet", local_quiet, 1'b0);
      sda = 1'b1; scl = 1'b1;
      peak = 1'b0;
      for (int k = 0; k < len; k++) begin
        step(1);
        peak = peak | local_quiet;
      end
      scl = 1'b0;
      for (int k = 0; k < 3; k++) begin
        step(1);
        peak = peak | local_quiet;
      end
      check("R3/R1 sweep quiet peak", peak, (len >= N) ? 1'b1 : 1'b0);
      check("R3 low cleared quiet", local_quiet, 1'b0);
      check("R5 no enable in sweep", drv_en, 1'b0);
    end

    // R2: STOP gives quiet without waiting
    far = 1'b1;
    scl = 1'b1; sda = 1'b0;
    step(4);
    check("R2 no quiet while SDA low", local_quiet, 1'b0);
    sda = 1'b1;
    step(2);
    check("R2 stop_det pulse", stop_det, 1'b1);
    check("R2 quiet not yet", local_quiet, 1'b0);
    step(1);
    check("R2 quiet after STOP", local_quiet, 1'b1);
    check("R2 stop_det one cycle", stop_det, 1'b0);
    step(1);
    check("R5 enable after STOP quiet", drv_en, 1'b1);

    // R4: START removes post-STOP quiet
    far = 1'b0;
    drop_pulse();
    sda = 1'b0;
    step(4);
    sda = 1'b1;
    step(3);
    check("R4 setup quiet via STOP", local_quiet, 1'b1);
    sda = 1'b0;
    step(2);
    check("R4 start_det pulse", start_det, 1'b1);
    step(1);
    check("R4 quiet cleared by START", local_quiet, 1'b0);
    check("R4 start_det one cycle", start_det, 1'b0);

    // R8: reset after connect
    sda = 1'b1; far = 1'b1;
    step(N + 6);
    check("R5 connected again", drv_en, 1'b1);
    rst = 1'b1;
    step(1);
    check("R8 reset drops enable", drv_en, 1'b0);
    check("R8 reset drops quiet", local_quiet, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule